// File: doc/BRIEF.md
# Single-Word MDIO Management Controller

This block lets software reach the management registers of an external Ethernet PHY through one 32-bit command/status word. Software writes the word with an operation code, a 5-bit PHY address, a 5-bit register number and, for a write, 16 data bits. The controller then runs a clause-22 management frame on the MDC clock and the bidirectional MDIO line. When the frame is over it raises a ready flag at bit 28. After a read, the 16 bits returned by the PHY replace the low half of the word.

The block contains its own MDC divider, which is derived from the system clock by a parameter. It also drives the output-enable of the MDIO pad. MDC is held low between transactions. The line is pulled high outside the chip, so a PHY address with nothing attached reads back as all ones. Software polls bit 28 until it reads 1, then reads the result from bits 15:0.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0x1000_0000 (ready flag at bit 28 set, every other bit 0), MDC is low and the MDIO output enable is 0 (line released).
- R2: Field layout: bits 27:26 opcode (01 write, 10 read), bits 25:21 PHY address, bits 20:16 register number, bits 15:0 data, bits 31:29 read 0. A write to the word while ready is 1 is accepted, and the ready flag reads 0 from the next clock cycle.
- R3: Each transaction has exactly 64 MDC rising edges. The bits on MDIO at those edges are 32 ones, then start 0,1, the two opcode bits, the PHY address, and the register number, each field MSB first.
- R4: On a write, the controller drives turnaround 1,0 and then the 16 data bits MSB first. When the write completes, the word reads back as the command with the ready flag set.
- R5: On a read, the output enable is 0 from the turnaround (bit 46 of the frame) through the last data bit. The 16 bits sampled on the rising MDC edges of frame bits 48..63 appear MSB first in bits 15:0 when ready returns.
- R6: Every one of the 32 PHY addresses can be used. A read from an address where no PHY answers returns 0xFFFF in bits 15:0.
- R7: The MDIO output and its enable change only when MDC falls or when a transaction starts, never while MDC is high. One MDC period lasts 2*DIV_HALF system clocks, and MDC stays low while idle.
- R8: A write to the word while ready is 0 is ignored. The running frame and the final contents of the word are those of the command that was accepted.
- R9: The ready flag stays 0 until the falling MDC edge that follows the 64th rising edge. It returns to 1 one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Value written to the command word |
| cmd_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO pad output enable (0 = released) |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench models a PHY at address 5 that decodes the frame straight from the MDIO line. It returns 0x5A00 OR the register number, and addresses 0 and 31 are left without a PHY, so the all-ones floating read is exercised at both ends of the address range. Each frame is rebuilt bit by bit at the MDC rising edges. A design that left the turnaround or data phase driven on a read shows up as bus contention or a nonzero enable sample. A design that shifted a field or got the bit order wrong shows up as frame mismatches. A design with an off-by-one bit count shows up as a count other than 64. A second command issued mid-frame must leave both the frame and the final word untouched. A monitor flags any change of MDIO while MDC is high, which catches designs that update the data on the wrong MDC edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;   // first turnaround bit
  localparam int DATA_POS  = 48;   // first data bit
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic [2:0]  rsvd;
    logic        rdy;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } cmd_word_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = en && (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: the clock parks low whenever the divider is disabled
  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] PRE_TA   = IDX_W'(TA_POS - 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic                 is_rd;
  logic [IDX_W-1:0]     idx;
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] frame_w;
  logic                 start_rd;

  assign start_rd = (op == OP_RD);
  assign frame_w  = {{PRE_LEN{1'b1}}, 2'b01, op, phy, regad,
                     start_rd ? 2'b11 : 2'b10,
                     start_rd ? 16'hFFFF : wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      is_rd   <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        is_rd   <= start_rd;
        idx     <= '0;
        shreg   <= {frame_w[FRAME_LEN-2:0], 1'b0};
        mdio_o  <= frame_w[FRAME_LEN-1];
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise_tick && is_rd && idx >= DAT_IDX)
          rdata <= {rdata[14:0], mdio_i};
        if (fall_tick) begin
          if (idx == LAST_IDX) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
          end else begin
            idx     <= idx + 1'b1;
            mdio_o  <= shreg[FRAME_LEN-1];
            shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
            mdio_oe <= !(is_rd && idx >= PRE_TA);
          end
        end
      end
    end
  end

  // R5: the pad is released through turnaround and data of a read
  a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && idx >= IDX_W'(TA_POS)) |-> !mdio_oe);
  // R1: no drive on the line while idle
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  // R9: completion only follows a falling tick of the last bit
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(fall_tick) && $past(idx) == LAST_IDX);
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  cmd_word_t   wr_w;
  logic        ready_q;
  logic [1:0]  op_q;
  logic [4:0]  phy_q;
  logic [4:0]  reg_q;
  logic [15:0] data_q;
  logic        accept;
  logic        eng_busy;
  logic        eng_done;
  logic [15:0] eng_rdata;
  logic        rise_tick;
  logic        fall_tick;
  logic        unused_ok;

  assign wr_w      = cmd_wdata;
  assign unused_ok = ^{wr_w.rsvd, wr_w.rdy};
  assign accept    = cmd_wr && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      op_q    <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
    end else if (accept) begin
      ready_q <= 1'b0;
      op_q    <= wr_w.op;
      phy_q   <= wr_w.phy;
      reg_q   <= wr_w.regad;
      data_q  <= wr_w.data;
    end else if (eng_done) begin
      ready_q <= 1'b1;
      if (op_q == OP_RD)
        data_q <= eng_rdata;
    end
  end

  assign cmd_rdata = {3'b000, ready_q, op_q, phy_q, reg_q, data_q};

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk       (clk),
    .rst       (rst),
    .en        (eng_busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .op        (wr_w.op),
    .phy       (wr_w.phy),
    .regad     (wr_w.regad),
    .wdata     (wr_w.data),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (eng_busy),
    .done      (eng_done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rdata     (eng_rdata)
  );

  // R2: an accepted command clears the ready flag
  a_r2_ready_clears: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ready_q);
  // R8: a command written while not ready leaves the stored fields alone
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !ready_q && !eng_done) |=>
      $stable(op_q) && $stable(phy_q) && $stable(reg_q) && $stable(data_q));
  // R7: data and enable hold across the rising edge of MDC
  a_r7_stable_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb_top;
  localparam int DIV_HALF = 4;
  localparam int NV = 6;
  localparam logic [1:0]  V_OP  [NV] = '{2'b01, 2'b10, 2'b10, 2'b01, 2'b10, 2'b10};
  localparam logic [4:0]  V_PHY [NV] = '{5'd5, 5'd5, 5'd31, 5'd0, 5'd0, 5'd5};
  localparam logic [4:0]  V_REG [NV] = '{5'h1F, 5'h02, 5'h03, 5'h00, 5'h01, 5'h1D};
  localparam logic [15:0] V_DAT [NV] = '{16'hA5C3, 16'h0000, 16'h1234, 16'h0000, 16'h0000, 16'hFFFF};
  localparam logic [15:0] V_EXP [NV] = '{16'hA5C3, 16'h5A02, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h5A1D};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_line;
  logic phy_drv = 1'b0;
  logic phy_val = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rcount = 0;
  int contention = 0;
  int edge_viol = 0;
  int rise_cyc [2];
  logic [0:63] bits_s;
  logic [0:63] oe_s;
  logic prev_o, prev_oe;
  bit finished = 0;

  always #2 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_cmd_ctrl #(.DIV_HALF(DIV_HALF)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // PHY model: samples on MDC rise, answers reads to address 5
  always @(posedge mdc) begin
    if (mdio_oe && phy_drv) contention = contention + 1;
    if (rcount < 64) begin
      bits_s[rcount] = mdio_line;
      oe_s[rcount]   = mdio_oe;
      if (rcount < 2) rise_cyc[rcount] = cyc;
      rcount = rcount + 1;
    end
  end

  always @(negedge mdc) begin
    logic [15:0] v;
    v = 16'h5A00 | {11'b0, bits_s[41:45]};
    if (rcount >= 47 && rcount < 64 && bits_s[34:35] == 2'b10 &&
        bits_s[36:40] == 5'd5) begin
      phy_drv = 1'b1;
      phy_val = (rcount == 47) ? 1'b0 : v[63 - rcount];
    end else begin
      phy_drv = 1'b0;
    end
  end

  // R7 monitor: outputs must not move while MDC is high
  always @(negedge clk) begin
    if (!rst && mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe))
      edge_viol = edge_viol + 1;
    prev_o  = mdio_o;
    prev_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] d);
    @(negedge clk);
    cmd_wdata = {3'b000, 1'b0, op, phy, rg, d};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_ready();
    while (!cmd_rdata[28]) @(negedge clk);
  endtask

  task automatic check_frame(input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] d,
                             input logic [15:0] exp);
    logic [63:0] ef;
    int lim;
    int bad;
    int oebad;
    ef = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
    lim = (op == 2'b10) ? 46 : 64;
    bad = 0;
    oebad = 0;
    for (int i = 0; i < lim; i++)
      if (bits_s[i] !== ef[63 - i]) bad = bad + 1;
    if (op == 2'b10)
      for (int i = 46; i < 64; i++)
        if (oe_s[i] !== 1'b0) oebad = oebad + 1;
    chk(rcount == 64, "R3 rising edge count", rcount, 64);
    chk(bad == 0, (op == 2'b10) ? "R3 header bits" : "R4 driven frame bits", bad, 0);
    if (op == 2'b10) chk(oebad == 0, "R5 released from turnaround", oebad, 0);
    chk(cmd_rdata === {3'b000, 1'b1, op, phy, rg, exp},
        (op == 2'b10) ? ((exp == 16'hFFFF) ? "R6 readback" : "R5 readback")
                      : "R4 readback",
        cmd_rdata, {3'b000, 1'b1, op, phy, rg, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(cmd_rdata === 32'h1000_0000, "R1 word after reset", cmd_rdata, 32'h1000_0000);
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R1 pad released, MDC low",
        {mdc, mdio_oe}, 0);

    // table of transactions
    for (int k = 0; k < NV; k++) begin
      rcount = 0;
      issue(V_OP[k], V_PHY[k], V_REG[k], V_DAT[k]);
      chk(cmd_rdata[28] === 1'b0, "R2 ready cleared", cmd_rdata[28], 0);
      chk(cmd_rdata[27:0] === {V_OP[k], V_PHY[k], V_REG[k], V_DAT[k]},
          "R2 field layout", cmd_rdata[27:0], {V_OP[k], V_PHY[k], V_REG[k], V_DAT[k]});
      wait_ready();
      check_frame(V_OP[k], V_PHY[k], V_REG[k], V_DAT[k], V_EXP[k]);
      if (k == 0)
        chk(rise_cyc[1] - rise_cyc[0] == 2 * DIV_HALF, "R7 MDC period",
            rise_cyc[1] - rise_cyc[0], 2 * DIV_HALF);
    end

    // R9: ready must not return before the whole frame
    rcount = 0;
    issue(2'b01, 5'd3, 5'd4, 16'h0F0F);
    while (rcount < 64) begin
      if (cmd_rdata[28]) begin
        chk(1'b0, "R9 early ready", rcount, 64);
        break;
      end
      @(negedge clk);
    end
    chk(cmd_rdata[28] === 1'b0, "R9 not ready at last rise", cmd_rdata[28], 0);
    wait_ready();
    check_frame(2'b01, 5'd3, 5'd4, 16'h0F0F, 16'h0F0F);

    // R8: second command mid-frame is ignored
    rcount = 0;
    issue(2'b01, 5'd5, 5'd4, 16'h1111);
    repeat (100) @(negedge clk);
    cmd_wdata = {3'b000, 1'b0, 2'b10, 5'd9, 5'd9, 16'h2222};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    wait_ready();
    chk(cmd_rdata === {4'b0001, 2'b01, 5'd5, 5'd4, 16'h1111}, "R8 word kept",
        cmd_rdata, {4'b0001, 2'b01, 5'd5, 5'd4, 16'h1111});
    check_frame(2'b01, 5'd5, 5'd4, 16'h1111, 16'h1111);

    repeat (10) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R7 idle MDC low, pad released",
        {mdc, mdio_oe}, 0);
    chk(edge_viol == 0, "R7 no change while MDC high", edge_viol, 0);
    chk(contention == 0, "R5 no bus contention", contention, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule